// File: doc/BRIEF.md
# Nibble Command Parser

This block sits behind a host write port and turns the stream of beats it delivers into decoded commands. In the normal narrow mode each beat carries a four-bit nibble and a tag bit that marks it as command or speech data. Command nibbles are gathered into a header, a first-level parameter of one or two nibbles and, for some headers, a four-nibble second-level parameter. Every multi-nibble field arrives most significant nibble first. Data-tagged beats go straight through to a speech data stream.

Once a command is complete and legal, the parser raises a one-cycle strobe carrying the header and both parameter fields. An illegal header or parameter does not produce a strobe. Instead it places the fixed error word 0x9999 in a single-entry return holding register. The same register holds the buffer byte count that the buffer query command asks for. A play command that selects 8-bit transfer puts the parser in wide mode. In wide mode every beat is forwarded as a full data byte and no command is decoded. A phrase-end pulse returns the parser to narrow mode.

The input, the data output and the return word are valid/ready streams. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a return word is unsent. For a data beat, `in_ready` also follows `dat_ready`. `dat_valid` never waits on `dat_ready`. A return word stays on `ret_word` until the edge where `ret_ready` is high.

Top module: `nibble_cmd_parser`

## Requirements
- R1: After reset, `cmd_valid`, `ret_valid` and `dat_wide` are 0, and `in_ready` is 1.
- R2: In narrow mode, `in_bus[4]`=1 marks a data beat. It appears on `dat_valid` with `dat_val` = {4'b0, `in_bus[3:0]`} and `dat_wide`=0, and `in_ready` follows `dat_ready`. `in_bus[4]`=0 marks a command nibble on `in_bus[3:0]`.
- R3: Header 0x1 takes a two-nibble address and then a four-nibble word, each most significant nibble first. They appear as `cmd_p1` and `cmd_p2`.
- R4: The following headers take one parameter nibble, reported in `cmd_p1[3:0]` with `cmd_p2`=0:
  - 0x2 and 0x9 accept any value.
  - 0x4 accepts 0x1 to 0x7.
  - 0x5 and 0x8 accept 0x1 to 0x3.
  - 0x6 accepts 0x1 to 0x6.
  - 0xB accepts 0x1 to 0x2.
- R5: Headers 0x0, 0x3 and 0xC to 0xF load 0x9999 into the return register and give no strobe.
- R6: A parameter nibble outside its header's range loads 0x9999, gives no strobe and returns the parser to header phase.
- R7: Header 0x7 with parameter 0x1 returns `fill_spch`, and with parameter 0x2 returns `fill_fm`. Either value is sampled on the edge that takes the parameter. The command also strobes. Any other parameter returns 0x9999.
- R8: Header 0xA with parameter 0x0 to 0x2 takes four more nibbles. With parameter 0x3 it completes at once with `cmd_p2`=0. Any parameter above 0x3 is an error.
- R9: A data beat that arrives after a header and before the command is complete aborts the command and loads 0x9999. The beat is still forwarded.
- R10: The return word is held stable, with `ret_valid` high, until `ret_ready`. While `ret_valid` is high, `in_ready` is 0.
- R11: Header 0x4 with parameter 0x2 enters wide mode. In wide mode:
  - every beat goes to the data stream as the full `in_bus` byte with `dat_wide`=1, and `in_bus[4]` is ignored;
  - no command is decoded and no error is raised.
  A `phrase_end` pulse returns the parser to narrow mode.
- R12: `cmd_valid` is a single-cycle pulse in the cycle after the final nibble is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted on this edge when valid |
| in_bus | input | 8 | Beat: nibble in [3:0], tag in [4] (narrow); byte (wide) |
| dat_valid | output | 1 | Speech data valid |
| dat_ready | input | 1 | Speech data sink ready |
| dat_val | output | 8 | Speech data nibble or byte |
| dat_wide | output | 1 | 1 while in wide (byte) mode |
| cmd_valid | output | 1 | Decoded command strobe |
| cmd_hdr | output | 4 | Command header |
| cmd_p1 | output | 8 | First-level parameter |
| cmd_p2 | output | 16 | Second-level parameter |
| ret_valid | output | 1 | Return word pending |
| ret_ready | input | 1 | Return word taken |
| ret_word | output | 16 | Return word |
| fill_spch | input | 16 | Bytes needed to fill the speech buffer |
| fill_fm | input | 16 | Bytes needed to fill the FM buffer |
| phrase_end | input | 1 | Pulse ending a wide-mode phrase |

## Verification
The hardest case to reach from the ports is a return word that is still unsent while the host keeps offering more input. Reaching it needs the return sink to be held off after an error, with a beat already waiting. The bench forces an illegal header with `ret_ready` low and then presents a legal header. It checks over several cycles that the word stays put and the beat is refused. It then releases the sink and confirms that the held beat starts a fresh command.

A second hard case is a command nibble while in wide mode. The bench reaches it by completing the 8-bit play command first. It then sends beats with the tag bit low that would otherwise be an illegal header.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {PH_HDR, PH_P1, PH_P2} phase_e;

  localparam logic [NIB_W-1:0] H_CFG   = 4'h1;
  localparam logic [NIB_W-1:0] H_PORT  = 4'h2;
  localparam logic [NIB_W-1:0] H_PLAY  = 4'h4;
  localparam logic [NIB_W-1:0] H_STOP  = 4'h5;
  localparam logic [NIB_W-1:0] H_VOL   = 4'h6;
  localparam logic [NIB_W-1:0] H_BUFQ  = 4'h7;
  localparam logic [NIB_W-1:0] H_SLEEP = 4'h8;
  localparam logic [NIB_W-1:0] H_FM    = 4'h9;
  localparam logic [NIB_W-1:0] H_SHIFT = 4'hA;
  localparam logic [NIB_W-1:0] H_OSC   = 4'hB;

  localparam logic [NIB_W-1:0] PLAY_WIDE  = 4'h2;
  localparam logic [NIB_W-1:0] BUFQ_SPCH  = 4'h1;
  localparam logic [NIB_W-1:0] SHIFT_NONE = 4'h3;
endpackage

// File: rtl/cmdp_decode.sv
module cmdp_decode
  import cmdp_pkg::*;
#(
  parameter int P1_NIBS = 2,
  parameter int CNT_W   = 2
) (
  input  logic [NIB_W-1:0] hdr_nib,
  input  logic [NIB_W-1:0] hdr_q,
  input  logic [NIB_W-1:0] p1_lo,
  output logic             hdr_ok,
  output logic [CNT_W:0]   p1_len,
  output logic             p1_ok,
  output logic             need_p2
);
  always_comb begin
    case (hdr_nib)
      H_CFG, H_PORT, H_PLAY, H_STOP, H_VOL, H_BUFQ,
      H_SLEEP, H_FM, H_SHIFT, H_OSC: hdr_ok = 1'b1;
      default:                       hdr_ok = 1'b0;
    endcase
  end

  assign p1_len = (hdr_q == H_CFG) ? (CNT_W+1)'(P1_NIBS) : (CNT_W+1)'(1);

  always_comb begin
    case (hdr_q)
      H_PLAY:          p1_ok = (p1_lo >= 4'h1) && (p1_lo <= 4'h7);
      H_STOP, H_SLEEP: p1_ok = (p1_lo >= 4'h1) && (p1_lo <= 4'h3);
      H_VOL:           p1_ok = (p1_lo >= 4'h1) && (p1_lo <= 4'h6);
      H_BUFQ, H_OSC:   p1_ok = (p1_lo >= 4'h1) && (p1_lo <= 4'h2);
      H_SHIFT:         p1_ok = (p1_lo <= SHIFT_NONE);
      default:         p1_ok = 1'b1;
    endcase
  end

  assign need_p2 = (hdr_q == H_CFG) || ((hdr_q == H_SHIFT) && (p1_lo != SHIFT_NONE));
endmodule

// File: rtl/cmdp_retq.sv
module cmdp_retq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  output logic         ret_valid,
  input  logic         ret_ready,
  output logic [W-1:0] ret_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_valid <= 1'b0;
      ret_word  <= '0;
    end else if (load) begin
      ret_valid <= 1'b1;
      ret_word  <= load_word;
    end else if (ret_ready) begin
      ret_valid <= 1'b0;
    end
  end

  a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> (ret_valid && $stable(ret_word)));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !ret_valid);
endmodule

// File: rtl/cmdp_mode.sv
module cmdp_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wide,
  input  logic clr_wide,
  output logic wide
);
  always_ff @(posedge clk) begin
    if (!rst_n)        wide <= 1'b0;
    else if (set_wide) wide <= 1'b1;
    else if (clr_wide) wide <= 1'b0;
  end
endmodule

// File: rtl/nibble_cmd_parser.sv
module nibble_cmd_parser
  import cmdp_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int TAG_BIT  = 4,
  parameter int P1_NIBS  = 2,
  parameter int P2_NIBS  = 4,
  parameter int RET_NIBS = 4,
  parameter logic [RET_NIBS*NIB_W-1:0] ERR_CODE = 'h9999
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [BUS_W-1:0]          in_bus,
  output logic                      dat_valid,
  input  logic                      dat_ready,
  output logic [BUS_W-1:0]          dat_val,
  output logic                      dat_wide,
  output logic                      cmd_valid,
  output logic [NIB_W-1:0]          cmd_hdr,
  output logic [P1_NIBS*NIB_W-1:0]  cmd_p1,
  output logic [P2_NIBS*NIB_W-1:0]  cmd_p2,
  output logic                      ret_valid,
  input  logic                      ret_ready,
  output logic [RET_NIBS*NIB_W-1:0] ret_word,
  input  logic [RET_NIBS*NIB_W-1:0] fill_spch,
  input  logic [RET_NIBS*NIB_W-1:0] fill_fm,
  input  logic                      phrase_end
);
  localparam int P1_W  = P1_NIBS * NIB_W;
  localparam int P2_W  = P2_NIBS * NIB_W;
  localparam int RET_W = RET_NIBS * NIB_W;
  localparam int CNT_W = $clog2(P2_NIBS);

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [NIB_W-1:0]  hdr_q, hdr_d;
  logic [P1_W-1:0]   p1_q, p1_d, p1_cand;
  logic [P2_W-1:0]   p2_q, p2_d, p2_cand;
  logic              wide_q, is_data, fire, cmd_fire;
  logic              err_ld, done, ret_ld;
  logic [RET_W-1:0]  ret_in;
  logic [NIB_W-1:0]  nib;
  logic              hdr_ok, p1_ok, need_p2;
  logic [CNT_W:0]    p1_len;

  assign nib      = in_bus[NIB_W-1:0];
  assign is_data  = wide_q | in_bus[TAG_BIT];
  assign in_ready = ~ret_valid & (is_data ? dat_ready : 1'b1);
  assign fire     = in_valid & in_ready;
  assign cmd_fire = fire & ~is_data;

  assign dat_valid = in_valid & ~ret_valid & is_data;
  assign dat_val   = wide_q ? in_bus : {{(BUS_W-NIB_W){1'b0}}, nib};
  assign dat_wide  = wide_q;

  assign p1_cand = {p1_q[P1_W-NIB_W-1:0], nib};
  assign p2_cand = {p2_q[P2_W-NIB_W-1:0], nib};

  cmdp_decode #(.P1_NIBS(P1_NIBS), .CNT_W(CNT_W)) u_dec (
    .hdr_nib (nib),
    .hdr_q   (hdr_q),
    .p1_lo   (p1_cand[NIB_W-1:0]),
    .hdr_ok  (hdr_ok),
    .p1_len  (p1_len),
    .p1_ok   (p1_ok),
    .need_p2 (need_p2)
  );

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    hdr_d  = hdr_q;
    p1_d   = p1_q;
    p2_d   = p2_q;
    err_ld = 1'b0;
    done   = 1'b0;
    if (fire && is_data && !wide_q) begin
      if (ph_q != PH_HDR) begin
        ph_d   = PH_HDR;
        err_ld = 1'b1;
      end
    end else if (cmd_fire) begin
      case (ph_q)
        PH_HDR: begin
          if (!hdr_ok) begin
            err_ld = 1'b1;
          end else begin
            hdr_d = nib;
            ph_d  = PH_P1;
            cnt_d = '0;
            p1_d  = '0;
            p2_d  = '0;
          end
        end
        PH_P1: begin
          p1_d = p1_cand;
          if (({1'b0, cnt_q} + (CNT_W+1)'(1)) < p1_len) begin
            cnt_d = cnt_q + CNT_W'(1);
          end else if (!p1_ok) begin
            err_ld = 1'b1;
            ph_d   = PH_HDR;
          end else if (need_p2) begin
            ph_d  = PH_P2;
            cnt_d = '0;
          end else begin
            done = 1'b1;
            ph_d = PH_HDR;
          end
        end
        default: begin
          p2_d = p2_cand;
          if (cnt_q == CNT_W'(P2_NIBS-1)) begin
            done = 1'b1;
            ph_d = PH_HDR;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign ret_ld = err_ld | (done && (hdr_q == H_BUFQ));
  assign ret_in = err_ld ? ERR_CODE :
                  ((p1_d[NIB_W-1:0] == BUFQ_SPCH) ? fill_spch : fill_fm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_HDR;
      cnt_q     <= '0;
      hdr_q     <= '0;
      p1_q      <= '0;
      p2_q      <= '0;
      cmd_valid <= 1'b0;
      cmd_hdr   <= '0;
      cmd_p1    <= '0;
      cmd_p2    <= '0;
    end else begin
      ph_q      <= ph_d;
      cnt_q     <= cnt_d;
      hdr_q     <= hdr_d;
      p1_q      <= p1_d;
      p2_q      <= p2_d;
      cmd_valid <= done;
      if (done) begin
        cmd_hdr <= hdr_q;
        cmd_p1  <= p1_d;
        cmd_p2  <= p2_d;
      end
    end
  end

  cmdp_retq #(.W(RET_W)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ret_ld),
    .load_word (ret_in),
    .ret_valid (ret_valid),
    .ret_ready (ret_ready),
    .ret_word  (ret_word)
  );

  cmdp_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_wide (done && (hdr_q == H_PLAY) && (p1_d[NIB_W-1:0] == PLAY_WIDE)),
    .clr_wide (phrase_end),
    .wide     (wide_q)
  );

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> !in_ready);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r11_wide_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wide && in_valid && in_ready) |=> !cmd_valid);

  a_r5_legal_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_hdr != 4'h0 && cmd_hdr != 4'h3 && cmd_hdr < 4'hC));
endmodule

// File: tb/tb_nibble_cmd_parser.sv
module tb_nibble_cmd_parser;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  // {count[76:74], nibbles[73:46], kind[45:44], hdr[43:40], p1[39:32], p2[31:16], ret[15:0]}
  // kind bit0: a command strobe is expected, bit1: a return word is expected
  localparam logic [76:0] VECS [0:NV-1] = '{
    {3'd7, 28'h11CA5F0, 2'b01, 4'h1, 8'h1C, 16'hA5F0, 16'h0000},
    {3'd2, 28'h2900000, 2'b01, 4'h2, 8'h09, 16'h0000, 16'h0000},
    {3'd2, 28'h6600000, 2'b01, 4'h6, 8'h06, 16'h0000, 16'h0000},
    {3'd2, 28'h6700000, 2'b10, 4'h0, 8'h00, 16'h0000, 16'h9999},
    {3'd2, 28'h6000000, 2'b10, 4'h0, 8'h00, 16'h0000, 16'h9999},
    {3'd2, 28'h4700000, 2'b01, 4'h4, 8'h07, 16'h0000, 16'h0000},
    {3'd2, 28'h5400000, 2'b10, 4'h0, 8'h00, 16'h0000, 16'h9999},
    {3'd2, 28'h8300000, 2'b01, 4'h8, 8'h03, 16'h0000, 16'h0000},
    {3'd2, 28'hB300000, 2'b10, 4'h0, 8'h00, 16'h0000, 16'h9999},
    {3'd2, 28'hB100000, 2'b01, 4'hB, 8'h01, 16'h0000, 16'h0000},
    {3'd1, 28'h3000000, 2'b10, 4'h0, 8'h00, 16'h0000, 16'h9999},
    {3'd1, 28'h0000000, 2'b10, 4'h0, 8'h00, 16'h0000, 16'h9999},
    {3'd1, 28'hF000000, 2'b10, 4'h0, 8'h00, 16'h0000, 16'h9999},
    {3'd2, 28'h7100000, 2'b11, 4'h7, 8'h01, 16'h0000, 16'h0123},
    {3'd2, 28'h7200000, 2'b11, 4'h7, 8'h02, 16'h0000, 16'h0456},
    {3'd2, 28'h7300000, 2'b10, 4'h0, 8'h00, 16'h0000, 16'h9999},
    {3'd2, 28'hA300000, 2'b01, 4'hA, 8'h03, 16'h0000, 16'h0000},
    {3'd6, 28'hA112340, 2'b01, 4'hA, 8'h01, 16'h1234, 16'h0000},
    {3'd2, 28'hA400000, 2'b10, 4'h0, 8'h00, 16'h0000, 16'h9999},
    {3'd2, 28'h9F00000, 2'b01, 4'h9, 8'h0F, 16'h0000, 16'h0000},
    {3'd2, 28'h5100000, 2'b01, 4'h5, 8'h01, 16'h0000, 16'h0000},
    {3'd7, 28'h1FF0001, 2'b01, 4'h1, 8'hFF, 16'h0001, 16'h0000},
    {3'd2, 28'h4100000, 2'b01, 4'h4, 8'h01, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_bus = 8'h00;
  logic        dat_valid;
  logic        dat_ready = 1'b1;
  logic [7:0]  dat_val;
  logic        dat_wide;
  logic        cmd_valid;
  logic [3:0]  cmd_hdr;
  logic [7:0]  cmd_p1;
  logic [15:0] cmd_p2;
  logic        ret_valid;
  logic        ret_ready = 1'b1;
  logic [15:0] ret_word;
  logic [15:0] fill_spch = 16'h0123;
  logic [15:0] fill_fm = 16'h0456;
  logic        phrase_end = 1'b0;

  int checks = 0;
  int failures = 0;
  int cmd_cnt = 0;
  int ret_cnt = 0;
  logic [3:0]  l_hdr = '0;
  logic [7:0]  l_p1 = '0;
  logic [15:0] l_p2 = '0;
  logic [15:0] l_ret = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_cmd_parser dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bus(in_bus),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_val(dat_val), .dat_wide(dat_wide),
    .cmd_valid(cmd_valid), .cmd_hdr(cmd_hdr), .cmd_p1(cmd_p1), .cmd_p2(cmd_p2),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_word(ret_word),
    .fill_spch(fill_spch), .fill_fm(fill_fm), .phrase_end(phrase_end)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      cmd_cnt = cmd_cnt + 1;
      l_hdr = cmd_hdr; l_p1 = cmd_p1; l_p2 = cmd_p2;
    end
    if (ret_valid && ret_ready) begin
      ret_cnt = ret_cnt + 1;
      l_ret = ret_word;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_beat(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bus = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tag_for(input logic [76:0] v);
    logic [3:0] h;
    h = v[73:70];
    if (h == 4'h1) return "R3";
    if (h == 4'h7) return "R7";
    if (h == 4'hA) return "R8";
    if (v[45:44] == 2'b10 && v[76:74] == 3'd1) return "R5";
    if (v[45:44] == 2'b10) return "R6";
    return "R4";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    int c0, r0;
    idle(3);
    // R1 reset state
    check(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
    check(ret_valid == 1'b0, "R1 ret_valid", ret_valid, 0);
    check(dat_wide == 1'b0, "R1 dat_wide", dat_wide, 0);
    rst_n = 1'b1;
    idle(1);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [76:0] v;
      string t;
      v = VECS[i];
      t = tag_for(v);
      c0 = cmd_cnt; r0 = ret_cnt;
      for (int k = 0; k < int'(v[76:74]); k++)
        send_beat({4'h0, v[73-4*k -: 4]});
      idle(3);
      check((cmd_cnt - c0) == int'(v[44]), t, cmd_cnt - c0, v[44]);
      if (v[44]) begin
        check(l_hdr == v[43:40], t, l_hdr, v[43:40]);
        check(l_p1 == v[39:32], t, l_p1, v[39:32]);
        check(l_p2 == v[31:16], t, l_p2, v[31:16]);
      end
      check((ret_cnt - r0) == int'(v[45]), t, ret_cnt - r0, v[45]);
      if (v[45]) check(l_ret == v[15:0], t, l_ret, v[15:0]);
    end

    // R2 data beat with back-pressure
    r0 = ret_cnt;
    dat_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_bus = 8'h1A;
    idle(1);
    check(dat_valid == 1'b1, "R2 dat_valid", dat_valid, 1);
    check(dat_val == 8'h0A, "R2 dat_val", dat_val, 8'h0A);
    check(dat_wide == 1'b0, "R2 dat_wide", dat_wide, 0);
    check(in_ready == 1'b0, "R2 in_ready held", in_ready, 0);
    dat_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R2 in_ready follows", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    idle(2);
    check(ret_cnt == r0, "R2 no error", ret_cnt - r0, 0);

    // R12 pulse width
    send_beat(8'h02);
    send_beat(8'h03);
    check(cmd_valid == 1'b1, "R12 pulse high", cmd_valid, 1);
    idle(1);
    check(cmd_valid == 1'b0, "R12 pulse low", cmd_valid, 0);

    // R9 data beat mid-command
    c0 = cmd_cnt; r0 = ret_cnt;
    send_beat(8'h06);
    @(negedge clk);
    in_valid = 1'b1; in_bus = 8'h13;
    #1;
    check(dat_valid == 1'b1 && dat_val == 8'h03, "R9 data forwarded", dat_val, 8'h03);
    @(negedge clk);
    in_valid = 1'b0;
    idle(3);
    check(ret_cnt - r0 == 1 && l_ret == 16'h9999, "R9 abort error", l_ret, 16'h9999);
    check(cmd_cnt == c0, "R9 no strobe", cmd_cnt - c0, 0);
    send_beat(8'h06);
    send_beat(8'h02);
    idle(2);
    check(cmd_cnt - c0 == 1 && l_hdr == 4'h6 && l_p1 == 8'h02, "R9 restart", {l_hdr, l_p1}, 12'h602);

    // R10 held return word stalls input
    ret_ready = 1'b0;
    send_beat(8'h0E);
    @(negedge clk);
    in_valid = 1'b1; in_bus = 8'h06;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(ret_valid == 1'b1 && ret_word == 16'h9999, "R10 word held", ret_word, 16'h9999);
      check(in_ready == 1'b0, "R10 stall", in_ready, 0);
    end
    ret_ready = 1'b1;
    @(negedge clk);
    check(ret_valid == 1'b0 && in_ready == 1'b1, "R10 release", {ret_valid, in_ready}, 2'b01);
    @(negedge clk);
    in_valid = 1'b0;
    c0 = cmd_cnt;
    send_beat(8'h01);
    idle(2);
    check(cmd_cnt - c0 == 1 && l_hdr == 4'h6 && l_p1 == 8'h01, "R10 held beat used", {l_hdr, l_p1}, 12'h601);

    // R11 wide mode
    send_beat(8'h04);
    send_beat(8'h02);
    idle(1);
    check(dat_wide == 1'b1, "R11 enter wide", dat_wide, 1);
    c0 = cmd_cnt; r0 = ret_cnt;
    @(negedge clk);
    in_valid = 1'b1; in_bus = 8'h05;
    #1;
    check(dat_valid == 1'b1 && dat_val == 8'h05, "R11 byte forwarded", dat_val, 8'h05);
    @(negedge clk);
    in_bus = 8'hEE;
    #1;
    check(dat_val == 8'hEE && dat_wide == 1'b1, "R11 full byte", dat_val, 8'hEE);
    @(negedge clk);
    in_valid = 1'b0;
    send_beat(8'h0E);
    idle(3);
    check(cmd_cnt == c0 && ret_cnt == r0, "R11 no decode", cmd_cnt - c0 + ret_cnt - r0, 0);
    phrase_end = 1'b1;
    @(negedge clk);
    phrase_end = 1'b0;
    check(dat_wide == 1'b0, "R11 phrase end", dat_wide, 0);
    send_beat(8'h05);
    send_beat(8'h01);
    idle(2);
    check(cmd_cnt - c0 == 1 && l_hdr == 4'h5, "R11 narrow again", l_hdr, 4'h5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule